// File: doc/BRIEF.md
# Masked Associative Search Array

This block is a small content-addressable store of sixteen 16-bit words. Each word has a valid flag. A masked search checks every word in the same cycle against a key. Bit positions that the mask disables are left out of the compare. The result is a match vector with one bit per word.

The block holds four working registers:
- a key register (`compareKey`);
- a bit-enable mask register (`compareMask`);
- a current match vector (`matchNow`);
- a previous match vector (`matchPrev`).

Each register can be loaded with any pattern, filled with ones, or cleared. A search moves the current match vector into the previous one before it writes the new result. Three Boolean combine commands then merge the two vectors back into the current one. This lets software refine a result over several searches.

Priority logic follows the current match vector. It reports whether any word matched and gives the lowest matching index. A read-first command returns the word at that index.

All commands arrive on a single command port, one per cycle. Every command takes effect at the clock edge on which it is presented. A read answers one cycle later on the read outputs.

Top module: `assoc_match_array`

## Requirements
- R1: After reset (`rstN` low), these are all zero: the key, the mask, both match vectors, every valid flag, every stored word, `rdValid`, `rdData` and `rdHit`.
- R2: Opcode 1 stores `cmdData` at word `cmdAddr` and sets its valid flag. Opcode 3 clears the valid flag of word `cmdAddr` and keeps its data.
- R3: Opcode 2 (read) raises `rdValid` on the next cycle. `rdData` then carries the word at `cmdAddr` and `rdHit` its valid flag.
- R4: The load opcodes copy a pattern into a register: opcode 4 loads the key from `cmdData`, opcode 5 loads the mask from `cmdData`, opcode 6 loads the current match vector from `cmdVec`, and opcode 7 loads the previous match vector from `cmdVec`.
- R5: Opcode 8 fills one register with all ones and opcode 9 clears it to zero. `cmdAddr[1:0]` picks the register: 0 for the key, 1 for the mask, 2 for the current match vector, 3 for the previous match vector.
- R6: Opcode 10 (search) writes into the current match vector one bit per word. Word i matches when it is valid and, for every bit j with mask bit j equal to 1, its stored bit j equals key bit j. An all-zero mask therefore matches every valid word. The result is visible on the cycle after the command.
- R7: On the same edge as a search, the previous match vector takes the old current match vector.
- R8: A word whose valid flag is clear never matches, whatever its data, key and mask.
- R9: The combine opcodes write a new current match vector from the current (I) and previous (T) vectors: opcode 11 writes I AND T, opcode 12 writes I OR T, and opcode 13 writes I AND NOT T. The previous match vector is left unchanged.
- R10: `anyMatch` is the OR of the current match vector. `firstIdx` is the lowest index set in it, or 0 when none is set. Both follow the register without a further cycle.
- R11: Opcode 14 (read first) raises `rdValid` on the next cycle. If the current match vector has any bit set, `rdData` is the word at its lowest set index and `rdHit` is 1. If no bit is set, `rdData` is 0 and `rdHit` is 0.
- R12: Opcodes 0 and 15, and any cycle with `cmdValid` low, leave every register and word unchanged, and `rdValid` reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Command opcode |
| cmdAddr | input | 4 | Word index, or register select in bits 1:0 |
| cmdData | input | 16 | Word data, key or mask pattern |
| cmdVec | input | 16 | Match-vector pattern for loads |
| rdValid | output | 1 | Read response strobe |
| rdData | output | 16 | Read response data |
| rdHit | output | 1 | Valid flag of the word read, or the match-found flag for read first |
| compareKey | output | 16 | Key register |
| compareMask | output | 16 | Mask register |
| matchNow | output | 16 | Current match vector |
| matchPrev | output | 16 | Previous match vector |
| anyMatch | output | 1 | At least one bit of the current match vector is set |
| firstIdx | output | 4 | Lowest set index of the current match vector |

## Verification
Searches are first run with an all-zero mask, which separates valid words from invalid ones, and then with a full mask, which tests exact equality. Partial masks follow: they show whether disabled bit positions really drop out, which they do only if words differing solely in those positions match together. A key that no word holds, a word invalidated after it matched, and read-first with an empty vector cover the empty-result paths. Chains of two searches followed by each combine opcode tell the three Boolean merges apart, and a long stretch of random commands drawn from a few repeating data values mixes everything against the reference model.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_WRITE   = 4'd1,
    OP_READ    = 4'd2,
    OP_INVAL   = 4'd3,
    OP_LDKEY   = 4'd4,
    OP_LDMASK  = 4'd5,
    OP_LDNOW   = 4'd6,
    OP_LDPREV  = 4'd7,
    OP_FILL    = 4'd8,
    OP_CLEAR   = 4'd9,
    OP_SEARCH  = 4'd10,
    OP_AND     = 4'd11,
    OP_OR      = 4'd12,
    OP_ANDN    = 4'd13,
    OP_RDFIRST = 4'd14,
    OP_IDLE    = 4'd15
  } assocOp_e;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_NOW  = 2'd2,
    SEL_PREV = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    COMB_NONE = 2'd0,
    COMB_AND  = 2'd1,
    COMB_OR   = 2'd2,
    COMB_ANDN = 2'd3
  } combOp_e;

  typedef struct packed {
    logic    wrWord;
    logic    invWord;
    logic    rdWord;
    logic    rdFirst;
    logic    ldKey;
    logic    ldMask;
    logic    ldNow;
    logic    ldPrev;
    logic    fillReg;
    logic    fillOnes;
    regSel_e fillSel;
    logic    search;
    combOp_e comb;
  } dpStrobe_t;

endpackage

// File: rtl/assoc_ctrl.sv
module assoc_ctrl
  import assoc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [3:0]      cmdOp,
  input  logic [1:0]      cmdSel,
  output dpStrobe_t       strobe,
  output logic            rdValid
);

  assocOp_e op;
  assign op = assocOp_e'(cmdOp);

  always_comb begin
    strobe = '0;
    strobe.fillSel = regSel_e'(cmdSel);
    strobe.comb = COMB_NONE;
    if (cmdValid) begin
      unique case (op)
        OP_WRITE:   strobe.wrWord  = 1'b1;
        OP_READ:    strobe.rdWord  = 1'b1;
        OP_INVAL:   strobe.invWord = 1'b1;
        OP_LDKEY:   strobe.ldKey   = 1'b1;
        OP_LDMASK:  strobe.ldMask  = 1'b1;
        OP_LDNOW:   strobe.ldNow   = 1'b1;
        OP_LDPREV:  strobe.ldPrev  = 1'b1;
        OP_FILL: begin
          strobe.fillReg  = 1'b1;
          strobe.fillOnes = 1'b1;
        end
        OP_CLEAR:   strobe.fillReg = 1'b1;
        OP_SEARCH:  strobe.search  = 1'b1;
        OP_AND:     strobe.comb    = COMB_AND;
        OP_OR:      strobe.comb    = COMB_OR;
        OP_ANDN:    strobe.comb    = COMB_ANDN;
        OP_RDFIRST: strobe.rdFirst = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobe.rdWord | strobe.rdFirst;
  end

  // R3 / R11: a read command yields a response strobe one cycle later
  a_r3_read_response: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOp == 4'd2 || cmdOp == 4'd14)) |=> rdValid);

  // R12: no command means no response
  a_r12_idle_no_response: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdValid) |=> !rdValid);

  // Decoder never raises two operations at once
  a_r12_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrWord, strobe.invWord, strobe.rdWord, strobe.rdFirst,
              strobe.ldKey, strobe.ldMask, strobe.ldNow, strobe.ldPrev,
              strobe.fillReg, strobe.search, strobe.comb != COMB_NONE}));

endmodule

// File: rtl/assoc_dpath.sv
module assoc_dpath
  import assoc_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_BITS = 16,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [IDX_W-1:0]     wordAddr,
  input  logic [WORD_BITS-1:0] dataIn,
  input  logic [NUM_WORDS-1:0] vecIn,
  output logic [WORD_BITS-1:0] rdData,
  output logic                 rdHit,
  output logic [WORD_BITS-1:0] keyReg,
  output logic [WORD_BITS-1:0] maskReg,
  output logic [NUM_WORDS-1:0] nowReg,
  output logic [NUM_WORDS-1:0] prevReg,
  output logic                 anyMatch,
  output logic [IDX_W-1:0]     firstIdx
);

  logic [WORD_BITS-1:0] wordMem [NUM_WORDS];
  logic [NUM_WORDS-1:0] validVec;
  logic [NUM_WORDS-1:0] hitVec;
  logic [NUM_WORDS-1:0] combVec;

  // Per-word masked compare, all words in parallel
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_cmp
    logic [WORD_BITS-1:0] diffBits;
    assign diffBits  = (wordMem[w] ^ keyReg) & maskReg;
    assign hitVec[w] = validVec[w] & ~(|diffBits);
  end

  always_comb begin
    unique case (strobe.comb)
      COMB_AND:  combVec = nowReg & prevReg;
      COMB_OR:   combVec = nowReg | prevReg;
      COMB_ANDN: combVec = nowReg & ~prevReg;
      default:   combVec = nowReg;
    endcase
  end

  // Priority encoder: lowest set index wins
  always_comb begin
    firstIdx = '0;
    for (int k = NUM_WORDS - 1; k >= 0; k--) begin
      if (nowReg[k]) firstIdx = IDX_W'(k);
    end
  end
  assign anyMatch = |nowReg;

  // Word storage and valid flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WORDS; w++) wordMem[w] <= '0;
      validVec <= '0;
    end else if (strobe.wrWord) begin
      wordMem[wordAddr]  <= dataIn;
      validVec[wordAddr] <= 1'b1;
    end else if (strobe.invWord) begin
      validVec[wordAddr] <= 1'b0;
    end
  end

  // Key and mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.ldKey) keyReg <= dataIn;
      else if (strobe.fillReg && strobe.fillSel == SEL_KEY)
        keyReg <= strobe.fillOnes ? '1 : '0;
      if (strobe.ldMask) maskReg <= dataIn;
      else if (strobe.fillReg && strobe.fillSel == SEL_MASK)
        maskReg <= strobe.fillOnes ? '1 : '0;
    end
  end

  // Current and previous match vectors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nowReg  <= '0;
      prevReg <= '0;
    end else begin
      if (strobe.search) begin
        nowReg  <= hitVec;
        prevReg <= nowReg;
      end else begin
        if (strobe.comb != COMB_NONE) nowReg <= combVec;
        else if (strobe.ldNow) nowReg <= vecIn;
        else if (strobe.fillReg && strobe.fillSel == SEL_NOW)
          nowReg <= strobe.fillOnes ? '1 : '0;
        if (strobe.ldPrev) prevReg <= vecIn;
        else if (strobe.fillReg && strobe.fillSel == SEL_PREV)
          prevReg <= strobe.fillOnes ? '1 : '0;
      end
    end
  end

  // Read response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdHit  <= 1'b0;
    end else if (strobe.rdWord) begin
      rdData <= wordMem[wordAddr];
      rdHit  <= validVec[wordAddr];
    end else if (strobe.rdFirst) begin
      rdData <= anyMatch ? wordMem[firstIdx] : '0;
      rdHit  <= anyMatch;
    end
  end

  // R7: search shifts the old current vector into the previous one
  a_r7_prev_takes_now: assert property (@(posedge clk) disable iff (!rstN)
    strobe.search |=> prevReg == $past(nowReg));

  // R8: invalid words never show up in a search result
  a_r8_invalid_never_hits: assert property (@(posedge clk) disable iff (!rstN)
    strobe.search |=> (nowReg & ~$past(validVec)) == '0);

  // R9: AND combine can only drop bits; combines leave previous intact
  a_r9_and_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.comb == COMB_AND) |=> (nowReg & ~$past(nowReg)) == '0);
  a_r9_prev_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.comb != COMB_NONE) |=> $stable(prevReg));

  // R10: reported index is set and nothing below it is
  a_r10_first_lowest: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch |-> (nowReg[firstIdx] &&
                  ((nowReg & ((NUM_WORDS'(1) << firstIdx) - NUM_WORDS'(1))) == '0)));
  a_r10_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    !anyMatch |-> (firstIdx == '0 && nowReg == '0));

  // R2: a written word becomes valid
  a_r2_write_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrWord |=> validVec[$past(wordAddr)]);

endmodule

// File: rtl/assoc_match_array.sv
module assoc_match_array
  import assoc_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_BITS = 16,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdOp,
  input  logic [IDX_W-1:0]     cmdAddr,
  input  logic [WORD_BITS-1:0] cmdData,
  input  logic [NUM_WORDS-1:0] cmdVec,
  output logic                 rdValid,
  output logic [WORD_BITS-1:0] rdData,
  output logic                 rdHit,
  output logic [WORD_BITS-1:0] compareKey,
  output logic [WORD_BITS-1:0] compareMask,
  output logic [NUM_WORDS-1:0] matchNow,
  output logic [NUM_WORDS-1:0] matchPrev,
  output logic                 anyMatch,
  output logic [IDX_W-1:0]     firstIdx
);

  dpStrobe_t  strobe;
  logic [1:0] regSel;

  if (IDX_W >= 2) begin : g_sel_wide
    assign regSel = cmdAddr[1:0];
  end else begin : g_sel_narrow
    assign regSel = {1'b0, cmdAddr[0]};
  end

  assoc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdSel   (regSel),
    .strobe   (strobe),
    .rdValid  (rdValid)
  );

  assoc_dpath #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_BITS (WORD_BITS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordAddr (cmdAddr),
    .dataIn   (cmdData),
    .vecIn    (cmdVec),
    .rdData   (rdData),
    .rdHit    (rdHit),
    .keyReg   (compareKey),
    .maskReg  (compareMask),
    .nowReg   (matchNow),
    .prevReg  (matchPrev),
    .anyMatch (anyMatch),
    .firstIdx (firstIdx)
  );

endmodule

// File: tb/assoc_match_array_tb.sv
`timescale 1ns/1ps
module assoc_match_array_tb_top;

  localparam int NW = 16;
  localparam int WB = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [3:0]    cmdOp = '0;
  logic [3:0]    cmdAddr = '0;
  logic [WB-1:0] cmdData = '0;
  logic [NW-1:0] cmdVec = '0;
  logic          rdValid, rdHit, anyMatch;
  logic [WB-1:0] rdData, compareKey, compareMask;
  logic [NW-1:0] matchNow, matchPrev;
  logic [3:0]    firstIdx;

  always #4 clk = ~clk;   // 125 MHz

  assoc_match_array dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdVec(cmdVec),
    .rdValid(rdValid), .rdData(rdData), .rdHit(rdHit),
    .compareKey(compareKey), .compareMask(compareMask),
    .matchNow(matchNow), .matchPrev(matchPrev),
    .anyMatch(anyMatch), .firstIdx(firstIdx)
  );

  // ---------------- reference model ----------------
  int unsigned mWord  [NW];
  bit          mValid [NW];
  int unsigned mKey, mMask, mNow, mPrev, mRdData;
  bit          mRdValid, mRdHit;

  function automatic int lowestSet(int unsigned v);
    for (int i = 0; i < NW; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NW; i++) begin mWord[i] = 0; mValid[i] = 0; end
      mKey = 0; mMask = 0; mNow = 0; mPrev = 0;
      mRdData = 0; mRdValid = 0; mRdHit = 0;
    end else begin
      mRdValid = 0;
      if (cmdValid) begin
        case (cmdOp)
          1: begin mWord[cmdAddr] = cmdData; mValid[cmdAddr] = 1; end
          2: begin mRdValid = 1; mRdData = mWord[cmdAddr]; mRdHit = mValid[cmdAddr]; end
          3: mValid[cmdAddr] = 0;
          4: mKey = cmdData;
          5: mMask = cmdData;
          6: mNow = cmdVec;
          7: mPrev = cmdVec;
          8, 9: begin
            int unsigned f;
            f = (cmdOp == 8) ? 32'hFFFF : 0;
            case (cmdAddr[1:0])
              0: mKey = f; 1: mMask = f; 2: mNow = f; default: mPrev = f;
            endcase
          end
          10: begin
            int unsigned res;
            res = 0;
            for (int w = 0; w < NW; w++) begin
              bit ok;
              ok = mValid[w];
              for (int b = 0; b < WB; b++)
                if (mMask[b] && (mWord[w][b] != mKey[b])) ok = 0;
              if (ok) res = res | (32'd1 << w);
            end
            mPrev = mNow; mNow = res;
          end
          11: mNow = mNow & mPrev;
          12: mNow = mNow | mPrev;
          13: mNow = mNow & ~mPrev & 32'hFFFF;
          14: begin
            int ls;
            ls = lowestSet(mNow);
            mRdValid = 1;
            mRdHit = (ls >= 0);
            mRdData = (ls >= 0) ? mWord[ls] : 0;
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- comparison ----------------
  int vectors = 0;
  int miscompares = 0;
  bit checking = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      int ls;
      vectors++;
      ls = lowestSet(mNow);
      chk("R4/R5", "compareKey", compareKey, mKey);
      chk("R4/R5", "compareMask", compareMask, mMask);
      chk("R6/R8/R9", "matchNow", matchNow, mNow);
      chk("R7", "matchPrev", matchPrev, mPrev);
      chk("R10", "anyMatch", anyMatch, (ls >= 0));
      chk("R10", "firstIdx", firstIdx, (ls >= 0) ? ls : 0);
      chk("R3/R11/R12", "rdValid", rdValid, mRdValid);
      if (mRdValid) begin
        chk("R3/R11", "rdData", rdData, mRdData);
        chk("R3/R11", "rdHit", rdHit, mRdHit);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(int op, int addr, int unsigned data, int unsigned vec);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = 4'(op);
    cmdAddr  = 4'(addr);
    cmdData  = WB'(data);
    cmdVec   = NW'(vec);
  endtask

  task automatic idle();
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp = $urandom_range(0, 15);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checking = 1;                          // R1: reset state compared first
    idle();
    // R2: fill words, two pairs that differ only in the low nibble
    issue(1, 3, 16'hA5C0, 0);
    issue(1, 7, 16'hA5C3, 0);
    issue(1, 9, 16'h1234, 0);
    issue(1, 12, 16'hA5C0, 0);
    issue(1, 0, 16'hFFFF, 0);
    // R3: read valid and unwritten words
    issue(2, 7, 0, 0);
    issue(2, 5, 0, 0);
    // R6: zero mask matches every valid word
    issue(10, 0, 0, 0);
    // R4/R6: full mask exact match
    issue(4, 0, 16'hA5C0, 0);
    issue(5, 0, 16'hFFFF, 0);
    issue(10, 0, 0, 0);                   // R7: previous gets old result
    // R6: partial mask ignores low nibble
    issue(5, 0, 16'hFFF0, 0);
    issue(10, 0, 0, 0);
    // R9: combine operations
    issue(11, 0, 0, 0);
    issue(10, 0, 0, 0);
    issue(12, 0, 0, 0);
    issue(13, 0, 0, 0);
    // R11: read first with a match present
    issue(10, 0, 0, 0);
    issue(14, 0, 0, 0);
    // R8: invalidate a matching word and search again
    issue(3, 3, 0, 0);
    issue(10, 0, 0, 0);
    issue(14, 0, 0, 0);
    issue(2, 3, 0, 0);
    // R11: absent key leaves nothing to read
    issue(4, 0, 16'h0BAD, 0);
    issue(10, 0, 0, 0);
    issue(14, 0, 0, 0);
    // R5: fill and clear each register
    for (int s = 0; s < 4; s++) begin
      issue(8, s, 0, 0);
      issue(9, s, 0, 0);
      issue(8, s, 0, 0);
    end
    // R4: direct vector loads, R10 priority on chosen patterns
    issue(6, 0, 0, 16'h8000);
    issue(7, 0, 0, 16'h0F0F);
    issue(6, 0, 0, 16'h0110);
    issue(14, 0, 0, 0);
    // R12: no-op opcodes and idle cycles
    issue(0, 4, 16'hDEAD, 16'hBEEF);
    issue(15, 4, 16'hDEAD, 16'hBEEF);
    idle(); idle();
    // random mix of all commands
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 15);
      if ($urandom_range(0, 9) == 0) idle();
      else issue(op, $urandom_range(0, 15),
                 ($urandom_range(0, 3) * 32'h1111) ^ $urandom_range(0, 3),
                 $urandom_range(0, 16'hFFFF));
    end
    idle(); idle();
    finishRun();
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule